// File: doc/BRIEF.md
# Single-Bank DRAM Command State Tracker

This block watches the command strobes of a double-data-rate DRAM interface on every clock and follows what one bank is doing with them. The four active-low strobes (chip select, row strobe, column strobe, write enable) are decoded into a command. That command is then applied to a five-state model of the bank: idle, row open, read burst, write burst and precharging. A controller or a protocol monitor uses the tracker to learn when a burst is cut short by a later command and when a command arrives that the bank cannot accept in its present state. It also gives an idle indication that a power-state tracker can use.

Bursts are counted in clocks: a burst of `BURST_LEN` beats moves two beats per clock, so it lasts `BURST_LEN/2` clocks. When it runs out undisturbed, the bank falls back to row open. A precharge holds the bank for `PRE_CLKS` clocks before it becomes idle. Commands are decoded only when clock enable was high at both the previous and the current edge. Otherwise the whole tracker, including its counters, holds still.

Top module: `bank_cmd_tracker`

## Requirements
- R1: While rst_n is low and after its release, bank_state is 0 (idle), bank_idle is 1, and burst_trunc and illegal_cmd are 0.
- R2: Decoding applies only with cs_n low. cs_n high is a deselect. With cs_n low, the pattern {ras_n,cas_n,we_n} decodes as follows: 111 NOP, 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 110 BURST STOP, 001 REFRESH, 000 MODE SET. Deselect and NOP leave the state unchanged. ACTIVE from idle moves bank_state to 1 (row open). The state codes are idle 0, row open 1, read 2, write 3, precharge 4.
- R3: In row open, READ enters state 2 and WRITE enters state 3. With no further command, the bank stays there for BURST_LEN/2 clocks and then returns to state 1.
- R4: A command outside the legal set of the current state raises illegal_cmd for one clock and leaves both the state and the remaining burst or precharge count unchanged. The legal sets are: idle {ACTIVE, REFRESH, MODE SET}; row open {READ, WRITE, PRECHARGE}; read {READ, PRECHARGE, BURST STOP}; write {READ, WRITE, PRECHARGE}; precharge {none}. Deselect and NOP are legal in every state.
- R5: During a read burst, READ restarts a full read burst, BURST STOP returns the bank to state 1, and PRECHARGE enters state 4. Each of these raises burst_trunc for one clock if the burst still had clocks left after the current one.
- R6: PRECHARGE enters state 4 for PRE_CLKS clocks and then state 0. bank_idle is 1 exactly when bank_state is 0.
- R7: A command at an edge where cke is low, or was low at the previous edge, has no effect. The state and the counters hold.
- R8: During a write burst, READ starts a read burst, WRITE starts a new write burst, and PRECHARGE enters state 4, with burst_trunc as in R5. A command in the final clock of a burst continues without a truncation pulse.
- R9: REFRESH and MODE SET in idle are accepted with no illegal flag, and the bank stays in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable sampled each edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_state | output | 3 | Bank state code (0 idle, 1 row open, 2 read, 3 write, 4 precharge) |
| bank_idle | output | 1 | High while the bank is idle |
| burst_trunc | output | 1 | One-clock pulse when a burst is cut short |
| illegal_cmd | output | 1 | One-clock pulse on a command not legal in the current state |

## Verification
Every output is registered. The state, the truncation pulse and the illegal flag that result from a command captured at an edge are therefore visible right after that same edge, and bank_idle follows the state directly. The bench drives each command on the falling edge and samples on the next falling edge, so every check falls exactly one clock after its command. Burst and precharge exits are checked by counting whole clocks: BURST_LEN/2 and PRE_CLKS samples after the starting command. After cke returns high, the first edge is still gated, so the bench expects the effect of a command only from the second edge.

// File: rtl/bank_cmd_pkg.sv
package bank_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_PRE  = 3'd4
  } bank_st_e;

  typedef enum logic [3:0] {
    C_DESEL,
    C_NOP,
    C_ACT,
    C_RD,
    C_WR,
    C_PRE,
    C_BST,
    C_REF,
    C_MRS
  } cmd_e;

  // Strobe pattern to command
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = C_NOP;
        3'b011:  c = C_ACT;
        3'b101:  c = C_RD;
        3'b100:  c = C_WR;
        3'b010:  c = C_PRE;
        3'b110:  c = C_BST;
        3'b001:  c = C_REF;
        default: c = C_MRS;
      endcase
    end
    return c;
  endfunction

  // Which commands a given state accepts
  function automatic logic cmd_legal(input bank_st_e st, input cmd_e c);
    logic ok;
    if (c == C_DESEL || c == C_NOP) begin
      ok = 1'b1;
    end else begin
      case (st)
        ST_IDLE: ok = (c inside {C_ACT, C_REF, C_MRS});
        ST_ROW:  ok = (c inside {C_RD, C_WR, C_PRE});
        ST_RD:   ok = (c inside {C_RD, C_PRE, C_BST});
        ST_WR:   ok = (c inside {C_RD, C_WR, C_PRE});
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  // Two beats move per clock
  function automatic int beats_to_clks(input int beats);
    return beats / 2;
  endfunction

  function automatic logic interrupts_burst(input cmd_e c);
    return (c inside {C_RD, C_WR, C_PRE, C_BST});
  endfunction

endpackage

// File: rtl/bank_cke_gate.sv
module bank_cke_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic dec_en
);
  logic cke_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_prev <= 1'b0;
    else        cke_prev <= cke;
  end

  assign dec_en = cke & cke_prev;

  // R7: enable never asserted unless cke was high one edge earlier
  a_r7_gate_needs_prev: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> $past(cke));

endmodule

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
  import bank_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/bank_fsm.sv
module bank_fsm
  import bank_cmd_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int PRE_CLKS  = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dec_en,
  input  cmd_e     cmd,
  output bank_st_e st,
  output logic     trunc,
  output logic     illegal
);
  localparam int BURST_CLKS = beats_to_clks(BURST_LEN);
  localparam int MAXC       = (BURST_CLKS > PRE_CLKS) ? BURST_CLKS : PRE_CLKS;
  localparam int CW         = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] BLOAD = CW'(BURST_CLKS - 1);
  localparam logic [CW-1:0] PLOAD = CW'(PRE_CLKS - 1);

  logic [CW-1:0] cnt, nxt_cnt;
  bank_st_e      nxt_st;
  logic          nxt_trunc, nxt_ill;
  logic          in_burst, legal;

  assign in_burst = (st == ST_RD) || (st == ST_WR);
  assign legal    = cmd_legal(st, cmd);

  always_comb begin
    nxt_st    = st;
    nxt_cnt   = cnt;
    nxt_trunc = 1'b0;
    nxt_ill   = 1'b0;
    if (dec_en) begin
      if (!legal) begin
        nxt_ill = 1'b1;
      end else begin
        case (st)
          ST_RD, ST_WR: begin
            if (cnt == '0) nxt_st = ST_ROW;
            else           nxt_cnt = cnt - 1'b1;
          end
          ST_PRE: begin
            if (cnt == '0) nxt_st = ST_IDLE;
            else           nxt_cnt = cnt - 1'b1;
          end
          default: ;
        endcase
        case (cmd)
          C_ACT: begin nxt_st = ST_ROW; nxt_cnt = '0;    end
          C_RD:  begin nxt_st = ST_RD;  nxt_cnt = BLOAD; end
          C_WR:  begin nxt_st = ST_WR;  nxt_cnt = BLOAD; end
          C_PRE: begin nxt_st = ST_PRE; nxt_cnt = PLOAD; end
          C_BST: begin nxt_st = ST_ROW; nxt_cnt = '0;    end
          default: ;
        endcase
        if (in_burst && (cnt != '0) && interrupts_burst(cmd)) nxt_trunc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      trunc   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      st      <= nxt_st;
      cnt     <= nxt_cnt;
      trunc   <= nxt_trunc;
      illegal <= nxt_ill;
    end
  end

  // R4: an illegal command leaves state and count untouched
  a_r4_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (st == $past(st)) && (cnt == $past(cnt)));

  // R5: truncation only ends a burst that was running
  a_r5_trunc_from_burst: assert property (@(posedge clk) disable iff (!rst_n)
    trunc |-> ($past(st) == ST_RD) || ($past(st) == ST_WR));

  // R6: idle is reached only out of precharge
  a_r6_idle_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) != ST_IDLE) |-> $past(st) == ST_PRE);

  // R7: a gated edge freezes everything
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dec_en) |-> (st == $past(st)) && (cnt == $past(cnt)) && !illegal && !trunc);

  // R3: burst count never above its load value
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RD) || (st == ST_WR)) |-> cnt <= BLOAD);

  // R4: flags never both high
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal && trunc));

endmodule

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker
  import bank_cmd_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int PRE_CLKS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  output logic [2:0] bank_state,
  output logic       bank_idle,
  output logic       burst_trunc,
  output logic       illegal_cmd
);
  logic     dec_en;
  cmd_e     cmd;
  bank_st_e st;

  bank_cke_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke    (cke),
    .dec_en (dec_en)
  );

  bank_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  bank_fsm #(
    .BURST_LEN (BURST_LEN),
    .PRE_CLKS  (PRE_CLKS)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_en  (dec_en),
    .cmd     (cmd),
    .st      (st),
    .trunc   (burst_trunc),
    .illegal (illegal_cmd)
  );

  assign bank_state = st;
  assign bank_idle  = (st == ST_IDLE);

endmodule

// File: tb/bank_cmd_tracker_test.sv
module bank_cmd_tracker_test;
  // strobes {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] K_DES = 4'b1011;
  localparam logic [3:0] K_NOP = 4'b0111;
  localparam logic [3:0] K_ACT = 4'b0011;
  localparam logic [3:0] K_RD  = 4'b0101;
  localparam logic [3:0] K_WR  = 4'b0100;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_BST = 4'b0110;
  localparam logic [3:0] K_REF = 4'b0001;
  localparam logic [3:0] K_MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0] bank_state;
  logic bank_idle, burst_trunc, illegal_cmd;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_cmd_tracker #(.BURST_LEN(4), .PRE_CLKS(3)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .bank_state(bank_state), .bank_idle(bank_idle),
    .burst_trunc(burst_trunc), .illegal_cmd(illegal_cmd)
  );

  task automatic chk(input string req, input logic [2:0] e_st,
                     input logic e_tr, input logic e_il);
    logic e_idle;
    e_idle = (e_st == 3'd0);
    checks++;
    if (bank_state !== e_st || bank_idle !== e_idle ||
        burst_trunc !== e_tr || illegal_cmd !== e_il) begin
      errors++;
      $display("FAIL %s: got st=%0d idle=%0b tr=%0b il=%0b, expected st=%0d idle=%0b tr=%0b il=%0b",
               req, bank_state, bank_idle, burst_trunc, illegal_cmd,
               e_st, e_idle, e_tr, e_il);
    end
  endtask

  // drive on falling edge, result visible one falling edge later
  task automatic step(input logic [3:0] k, input logic en = 1'b1);
    {cs_n, ras_n, cas_n, we_n} = k;
    cke = en;
    @(negedge clk);
  endtask

  task automatic go_idle(input string req);
    step(K_PRE); chk(req, 3'd4, 1'b0, 1'b0);
    step(K_NOP); chk(req, 3'd4, 1'b0, 1'b0);
    step(K_NOP); chk(req, 3'd4, 1'b0, 1'b0);
    step(K_NOP); chk(req, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk); chk("R1 in reset", 3'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(K_NOP); chk("R1 after reset", 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_decode;
    step(K_ACT); chk("R2 active", 3'd1, 1'b0, 1'b0);
    step(K_NOP); chk("R2 nop hold", 3'd1, 1'b0, 1'b0);
    step(K_DES); chk("R2 deselect hold", 3'd1, 1'b0, 1'b0);
    go_idle("R6 precharge from row");
  endtask

  task automatic t_natural;
    step(K_ACT);
    step(K_RD);  chk("R3 read start", 3'd2, 1'b0, 1'b0);
    step(K_NOP); chk("R3 read mid", 3'd2, 1'b0, 1'b0);
    step(K_NOP); chk("R3 read done", 3'd1, 1'b0, 1'b0);
    step(K_WR);  chk("R3 write start", 3'd3, 1'b0, 1'b0);
    step(K_NOP); chk("R3 write mid", 3'd3, 1'b0, 1'b0);
    step(K_NOP); chk("R3 write done", 3'd1, 1'b0, 1'b0);
    go_idle("R6 idle after bursts");
  endtask

  task automatic t_illegal;
    step(K_ACT);
    step(K_MRS); chk("R4 mode set in row", 3'd1, 1'b0, 1'b1);
    step(K_NOP); chk("R4 flag one clock", 3'd1, 1'b0, 1'b0);
    step(K_RD);
    step(K_WR);  chk("R4 write in read", 3'd2, 1'b0, 1'b1);
    step(K_NOP); chk("R4 count held", 3'd2, 1'b0, 1'b0);
    step(K_NOP); chk("R4 burst resumes end", 3'd1, 1'b0, 1'b0);
    step(K_PRE); chk("R6 pre", 3'd4, 1'b0, 1'b0);
    step(K_ACT); chk("R4 active in precharge", 3'd4, 1'b0, 1'b1);
    step(K_NOP); step(K_NOP); chk("R4 precharge count held", 3'd4, 1'b0, 1'b0);
    step(K_NOP); chk("R6 idle", 3'd0, 1'b0, 1'b0);
    step(K_RD);  chk("R4 read in idle", 3'd0, 1'b0, 1'b1);
    step(K_PRE); chk("R4 precharge in idle", 3'd0, 1'b0, 1'b1);
    step(K_BST); chk("R4 stop in idle", 3'd0, 1'b0, 1'b1);
    step(K_NOP);
  endtask

  task automatic t_read_int;
    step(K_ACT);
    step(K_RD);
    step(K_RD);  chk("R5 read restart", 3'd2, 1'b1, 1'b0);
    step(K_NOP); chk("R5 restart full", 3'd2, 1'b0, 1'b0);
    step(K_NOP); chk("R5 restart end", 3'd1, 1'b0, 1'b0);
    step(K_RD);
    step(K_BST); chk("R5 stop", 3'd1, 1'b1, 1'b0);
    step(K_RD);
    step(K_NOP);
    step(K_BST); chk("R5 stop last clock", 3'd1, 1'b0, 1'b0);
    step(K_RD);
    step(K_PRE); chk("R5 precharge in read", 3'd4, 1'b1, 1'b0);
    step(K_NOP); step(K_NOP); chk("R6 pre held", 3'd4, 1'b0, 1'b0);
    step(K_NOP); chk("R6 pre exit", 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_write_int;
    step(K_ACT);
    step(K_WR);
    step(K_RD);  chk("R8 read cuts write", 3'd2, 1'b1, 1'b0);
    step(K_NOP); step(K_NOP); chk("R8 read end", 3'd1, 1'b0, 1'b0);
    step(K_WR);
    step(K_WR);  chk("R8 write restart", 3'd3, 1'b1, 1'b0);
    step(K_NOP); chk("R8 last clock", 3'd3, 1'b0, 1'b0);
    step(K_WR);  chk("R8 seamless write", 3'd3, 1'b0, 1'b0);
    step(K_NOP); step(K_NOP); chk("R8 write end", 3'd1, 1'b0, 1'b0);
    step(K_WR);
    step(K_BST); chk("R4 stop in write", 3'd3, 1'b0, 1'b1);
    step(K_NOP); step(K_NOP); chk("R4 write end", 3'd1, 1'b0, 1'b0);
    step(K_WR);
    step(K_PRE); chk("R8 precharge in write", 3'd4, 1'b1, 1'b0);
    step(K_NOP); step(K_NOP); step(K_NOP); chk("R6 idle after write", 3'd0, 1'b0, 1'b0);
  endtask

  task automatic t_refresh;
    step(K_REF); chk("R9 refresh idle", 3'd0, 1'b0, 1'b0);
    step(K_MRS); chk("R9 mode set idle", 3'd0, 1'b0, 1'b0);
    step(K_ACT);
    step(K_REF); chk("R9 refresh in row", 3'd1, 1'b0, 1'b1);
    go_idle("R6 idle after refresh test");
  endtask

  task automatic t_cke;
    step(K_ACT, 1'b0); chk("R7 active gated", 3'd0, 1'b0, 1'b0);
    step(K_RD,  1'b0); chk("R7 illegal gated", 3'd0, 1'b0, 1'b0);
    step(K_ACT, 1'b1); chk("R7 first edge gated", 3'd0, 1'b0, 1'b0);
    step(K_ACT, 1'b1); chk("R7 active enabled", 3'd1, 1'b0, 1'b0);
    step(K_RD);
    step(K_NOP, 1'b0); step(K_NOP, 1'b0); step(K_NOP, 1'b0);
    chk("R7 burst frozen", 3'd2, 1'b0, 1'b0);
    step(K_NOP, 1'b1); chk("R7 rearm edge", 3'd2, 1'b0, 1'b0);
    step(K_NOP); chk("R7 burst last", 3'd2, 1'b0, 1'b0);
    step(K_NOP); chk("R7 burst done", 3'd1, 1'b0, 1'b0);
    go_idle("R6 idle after cke test");
  endtask

  initial begin
    t_reset();
    t_decode();
    t_natural();
    t_illegal();
    t_read_int();
    t_write_int();
    t_refresh();
    t_cke();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got no finish, expected finish before timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule